// File: doc/BRIEF.md
# Fuse-Configurable AND-OR Logic Array

This block is a small programmable logic array in sum-of-products form. Each primary input is split into two literals: its true value and its complement. A configuration store marks every crosspoint as intact or removed, in both planes. In the AND plane, an intact crosspoint puts a literal into a product term. In the OR plane, an intact crosspoint lets a product term reach an output. Each output is then the OR of the product terms still wired to it.

The configuration is a single chain of bits. It is loaded serially, one bit per clock, while `cfg_en` is high. The AND-plane bits come first, ordered term by term; the OR-plane bits follow, ordered output by output. The bit that leaves the far end of the chain is always visible on `cfg_do`. Software can therefore read the stored pattern back by shifting it out, and can keep it intact by feeding `cfg_do` back into `cfg_di`. While a load is in progress the outputs are forced low. Once `cfg_en` falls, evaluation of `din` is purely combinational.

Top module: `pla_array`

## Requirements
- R1: After reset every crosspoint is removed: `dout` is 0 for every `din` and `cfg_do` is 0.
- R2: Chain bit index `t*2*N_IN + 2*i` is the true literal of input `i` in product term `t`, and index `t*2*N_IN + 2*i + 1` is its complement. A bit of 1 (intact) puts the literal into the product and a 0 (removed) leaves it out.
- R3: A product term whose AND-plane crosspoints are all removed evaluates to 1.
- R4: Output `o` is the OR of the product terms whose OR-plane bit is 1, at chain index `N_TERM*2*N_IN + o*N_TERM + t`. An output with no connected term is 0.
- R5: Each clock edge with `cfg_en` high shifts `cfg_di` into the chain. After `CFG_BITS` such shifts, the first bit shifted sits at index 0 and the last at the top index.
- R6: `cfg_do` shows chain index 0. Shifting with `cfg_di` tied to `cfg_do` reads the pattern out in load order. A full pass of `CFG_BITS` shifts leaves the pattern unchanged.
- R7: While `cfg_en` is high, `dout` is 0 for every `din`.
- R8: While `cfg_en` is low, `cfg_di` has no effect and the stored pattern does not change.
- R9: A two-input XOR can be built from two product terms, A·B' and A'·B, both summed into one output.
- R10: A product term holding both the true and the complemented literal of the same input evaluates to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset; clears all crosspoints |
| cfg_en | input | 1 | Load/readback enable; shifts the chain and holds outputs low |
| cfg_di | input | 1 | Serial configuration data in |
| cfg_do | output | 1 | Serial configuration data out (chain index 0) |
| din | input | N_IN | Primary logic inputs |
| dout | output | N_OUT | Sum-of-products outputs |

## Verification
The assertions assume a specific input discipline:
- `rst_n` is held low for at least one clock edge before any use.
- `cfg_en` and `cfg_di` change only between clock edges, so each shift sees a settled bit.
- `din` may change at any time, because the assertions judge outputs only at clock edges.

The stimulus meets these assumptions by changing every input on the falling edge. It also keeps `cfg_en` high for exactly `CFG_BITS` edges per load or readback. The property that ties `cfg_do` to the next chain bit therefore always observes a complete pass.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;

  // Width of one AND-plane row: true and complement literal per input
  function automatic int row_width(input int n_in);
    return 2 * n_in;
  endfunction

  function automatic int and_plane_bits(input int n_in, input int n_term);
    return n_term * row_width(n_in);
  endfunction

  function automatic int or_plane_bits(input int n_term, input int n_out);
    return n_out * n_term;
  endfunction

  function automatic int total_bits(input int n_in, input int n_term, input int n_out);
    return and_plane_bits(n_in, n_term) + or_plane_bits(n_term, n_out);
  endfunction

  // Chain index of a literal crosspoint; inv selects the complement column
  function automatic int and_index(input int n_in, input int term, input int inp, input bit inv);
    return term * row_width(n_in) + 2 * inp + int'(inv);
  endfunction

  // Chain index of an OR-plane crosspoint
  function automatic int or_index(input int n_in, input int n_term, input int outp, input int term);
    return and_plane_bits(n_in, n_term) + outp * n_term + term;
  endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
`timescale 1ns/1ps
module pla_cfg_chain #(
  parameter int BITS = 80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            ser_in,
  output logic            ser_out,
  output logic [BITS-1:0] bits
);

  logic [BITS-1:0] chain_q;

  // New bit enters at the top; index 0 leaves first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (shift_en) begin
      chain_q <= {ser_in, chain_q[BITS-1:1]};
    end
  end

  assign bits    = chain_q;
  assign ser_out = chain_q[0];

endmodule

// File: rtl/pla_literals.sv
`timescale 1ns/1ps
module pla_literals #(
  parameter int N_IN = 4
) (
  input  logic [N_IN-1:0]   din,
  output logic [2*N_IN-1:0] lit
);

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]     = din[i];
    assign lit[2*i + 1] = ~din[i];
  end

endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8
) (
  input  logic [2*N_IN-1:0]        lit,
  input  logic [N_TERM*2*N_IN-1:0] plane,
  output logic [N_TERM-1:0]        term
);

  localparam int W = pla_pkg::row_width(N_IN);

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [W-1:0] row;
    assign row = plane[t*W +: W];
    // A removed crosspoint contributes a 1 to the product
    assign term[t] = &(~row | lit);
  end

endmodule

// File: rtl/pla_or_plane.sv
`timescale 1ns/1ps
module pla_or_plane #(
  parameter int N_TERM = 8,
  parameter int N_OUT  = 2
) (
  input  logic [N_TERM-1:0]       term,
  input  logic [N_OUT*N_TERM-1:0] plane,
  input  logic                    hold,
  output logic [N_OUT-1:0]        dout
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_TERM-1:0] sel;
    assign sel     = plane[o*N_TERM +: N_TERM];
    assign dout[o] = (|(sel & term)) & ~hold;
  end

endmodule

// File: rtl/pla_array.sv
`timescale 1ns/1ps
module pla_array #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_di,
  output logic             cfg_do,
  input  logic [N_IN-1:0]  din,
  output logic [N_OUT-1:0] dout
);

  localparam int AND_BITS = pla_pkg::and_plane_bits(N_IN, N_TERM);
  localparam int OR_BITS  = pla_pkg::or_plane_bits(N_TERM, N_OUT);
  localparam int CFG_BITS = AND_BITS + OR_BITS;

  logic [CFG_BITS-1:0] cfg_bits;
  logic [2*N_IN-1:0]   lit_vec;
  logic [N_TERM-1:0]   term_vec;

  pla_cfg_chain #(.BITS(CFG_BITS)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(cfg_en),
    .ser_in  (cfg_di),
    .ser_out (cfg_do),
    .bits    (cfg_bits)
  );

  pla_literals #(.N_IN(N_IN)) u_lit (
    .din(din),
    .lit(lit_vec)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .lit  (lit_vec),
    .plane(cfg_bits[AND_BITS-1:0]),
    .term (term_vec)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term (term_vec),
    .plane(cfg_bits[CFG_BITS-1:AND_BITS]),
    .hold (cfg_en),
    .dout (dout)
  );

endmodule

// File: rtl/pla_array_chk.sv
`timescale 1ns/1ps
module pla_array_chk #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic cfg_do,
  input logic [N_OUT-1:0] dout,
  input logic [pla_pkg::total_bits(N_IN, N_TERM, N_OUT)-1:0] cfg_bits,
  input logic [N_TERM-1:0] term_vec
);

  localparam int W        = pla_pkg::row_width(N_IN);
  localparam int AND_BITS = pla_pkg::and_plane_bits(N_IN, N_TERM);

  // R7
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (dout == '0));

  // R8
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_do));

  // R5
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (cfg_do == $past(cfg_bits[1])));

  for (genvar t = 0; t < N_TERM; t++) begin : g_t
    // R3
    empty_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bits[t*W +: W] == '0) |-> term_vec[t]);
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_o
    // R4
    or_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout[o] |-> ((cfg_bits[AND_BITS + o*N_TERM +: N_TERM] & term_vec) != '0));
  end

endmodule

bind pla_array pla_array_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_en  (cfg_en),
  .cfg_do  (cfg_do),
  .dout    (dout),
  .cfg_bits(cfg_bits),
  .term_vec(term_vec)
);

// File: tb/pla_array_test.sv
`timescale 1ns/1ps
module pla_array_test;

  localparam int NI = 4;
  localparam int NT = 8;
  localparam int NO = 2;
  localparam int AB = NT * 2 * NI;
  localparam int TB = AB + NO * NT;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_en = 1'b0;
  logic          cfg_di = 1'b0;
  logic          cfg_do;
  logic [NI-1:0] din = '0;
  logic [NO-1:0] dout;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  pla_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_di(cfg_di),
    .cfg_do(cfg_do), .din(din), .dout(dout)
  );

  function automatic logic [NO-1:0] model(input logic [TB-1:0] c, input logic [NI-1:0] x);
    logic [NT-1:0] p;
    logic [NO-1:0] r;
    for (int t = 0; t < NT; t++) begin
      p[t] = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (c[t*2*NI + 2*i] && !x[i]) p[t] = 1'b0;
        if (c[t*2*NI + 2*i + 1] && x[i]) p[t] = 1'b0;
      end
    end
    for (int o = 0; o < NO; o++) begin
      r[o] = 1'b0;
      for (int t = 0; t < NT; t++) if (c[AB + o*NT + t] && p[t]) r[o] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] v;
    v = s ^ (s << 13);
    v = v ^ (v >> 17);
    v = v ^ (v << 5);
    return v;
  endfunction

  task automatic check(input string req, input logic [TB-1:0] got, input logic [TB-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic load(input logic [TB-1:0] v);
    for (int k = 0; k < TB; k++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_di = v[k];
      #1;
      // R7: outputs held low during load
      check("R7", TB'(dout), '0);
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_di = 1'b0;
  endtask

  task automatic readback(output logic [TB-1:0] v);
    for (int k = 0; k < TB; k++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      #1;
      v[k] = cfg_do;
      cfg_di = cfg_do;
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_di = 1'b0;
  endtask

  task automatic sweep(input string req, input logic [TB-1:0] c);
    for (int x = 0; x < (1 << NI); x++) begin
      din = NI'(x);
      #1;
      check(req, TB'(dout), TB'(model(c, NI'(x))));
    end
  endtask

  initial begin
    logic [TB-1:0] cfg;
    logic [TB-1:0] rb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1", TB'(cfg_do), '0);
    for (int x = 0; x < (1 << NI); x++) begin
      din = NI'(x); #1;
      check("R1", TB'(dout), '0);
    end
    readback(rb);
    check("R1", rb, '0);

    // R9 / R3 / R4: XOR of in0,in1 on out0; empty term 2 on out1
    cfg = '0;
    cfg[0*2*NI + 0] = 1'b1; cfg[0*2*NI + 3] = 1'b1;
    cfg[1*2*NI + 1] = 1'b1; cfg[1*2*NI + 2] = 1'b1;
    cfg[AB + 0*NT + 0] = 1'b1; cfg[AB + 0*NT + 1] = 1'b1;
    cfg[AB + 1*NT + 2] = 1'b1;
    load(cfg);
    for (int x = 0; x < (1 << NI); x++) begin
      din = NI'(x); #1;
      check("R9", TB'(dout[0]), TB'(x[0] ^ x[1]));
      check("R3", TB'(dout[1]), TB'(1'b1));
    end

    // R4: output with no connected terms; R10: true and complement together
    cfg = '0;
    cfg[3*2*NI + 4] = 1'b1; cfg[3*2*NI + 5] = 1'b1;
    cfg[AB + 0*NT + 3] = 1'b1;
    load(cfg);
    for (int x = 0; x < (1 << NI); x++) begin
      din = NI'(x); #1;
      check("R10", TB'(dout[0]), '0);
      check("R4", TB'(dout[1]), '0);
    end

    // R2 / R4 / R5: pseudo-random patterns swept over all inputs
    for (int n = 0; n < 6; n++) begin
      for (int k = 0; k < TB; k++) begin
        seed = next_rand(seed);
        cfg[k] = (k < AB) ? (seed[3] & seed[9]) : seed[5];
      end
      load(cfg);
      sweep("R2", cfg);

      // R6: readback in load order, pattern preserved
      readback(rb);
      check("R6", rb, cfg);
      sweep("R5", cfg);

      // R8: cfg_di toggles with cfg_en low
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        seed = next_rand(seed);
        cfg_di = seed[0];
      end
      cfg_di = 1'b0;
      sweep("R8", cfg);
      readback(rb);
      check("R8", rb, cfg);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule